// File: doc/BRIEF.md
# Standby Entry and Wake-Up Sequencer

This block takes a processor core into a standby low-power mode and brings it back out. When the core raises an idle request, the sequencer waits a fixed entry delay. It then raises a clock-output-high indication and gates the core clock. While in standby it watches an asynchronous, active-low wake line. It passes that line through a two-flop synchronizer and counts consecutive low samples.

A wake is accepted once the line has stayed low for a minimum run of cycles. The run is fixed when qualification is off. When qualification is on, it is two plus a 6-bit programmable value. After acceptance the block waits a resume latency that depends on where code executes. Flash in its sleep state needs a long wake time. Active flash and on-chip SRAM need a short one. The block then ungates the clock and gives the core a one-cycle resume strobe.

All pins are plain control and status. There is no data stream, so there is no valid/ready handshake and no back-pressure. The input clock and the system clock are modelled as one clock. The qualification settings and the code-memory selection are captured when the idle request is accepted.

Top module: `stbw_ctrl`

## Requirements
- R1: When `idle_req` is high at a rising edge while the block is running (edge E0), `clkout_hi` rises and `core_clk_en` falls at edge E0+32. An `idle_req` seen at any other time has no effect.
- R2: With qualification off, a wake is accepted only after `wake_n` has been low for 12 or more consecutive cycles. A shorter low pulse is ignored: `clkout_hi` stays high and no resume strobe appears.
- R3: With qualification on, the required low run is 2 + `qual_width` cycles, so it ranges from 2 to 65. A shorter pulse is ignored and the block stays in standby.
- R4: Take S0 as the first rising edge at which `wake_n` is sampled low, with W the required run and L the resume latency. For an accepted wake, `resume_pulse` rises at edge S0+1+W+L. The extra cycle comes from the synchronizer.
- R5: The resume latency L is 12 cycles when `code_mem` is 0 (flash active), 2 (on-chip SRAM) or 3 (also treated as SRAM).
- R6: The resume latency L is 1125 cycles when `code_mem` is 1 (flash in sleep).
- R7: `resume_pulse` is high for exactly one cycle. In that same cycle `core_clk_en` is high and `clkout_hi` is low, and the block is back in its running state.
- R8: `qual_en`, `qual_width` and `code_mem` are captured at the edge that accepts the idle request. Changes to them afterwards are ignored until the next entry.
- R9: A wake that meets the required run while the entry delay is still counting is held pending. The block then leaves standby on the edge after it reaches standby, so `resume_pulse` rises at E0+33+L.
- R10: Reset (`rst_n` low) sets `clkout_hi` low, `core_clk_en` high and `resume_pulse` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock; input clock and system clock treated as equal |
| rst_n | input | 1 | Asynchronous active-low reset |
| idle_req | input | 1 | Request from the core to enter standby |
| wake_n | input | 1 | Asynchronous active-low external wake line |
| qual_en | input | 1 | 1 selects programmable wake qualification |
| qual_width | input | 6 | Qualification extension; required run is 2 + value |
| code_mem | input | 2 | Code location: 0 flash active, 1 flash sleep, 2/3 SRAM |
| clkout_hi | output | 1 | Clock-output-high indication while in standby |
| core_clk_en | output | 1 | Core clock enable, low while gated |
| resume_pulse | output | 1 | One-cycle strobe telling the core to resume |

## Verification
The bench targets the edges of the acceptance window. It drives pulses exactly one cycle short of the required run and exactly equal to it, for the fixed run of 12 and for the qualified runs of 2 and 65. An off-by-one in the run counter would either wake on the short pulse or reject the exact one. It also measures the entry delay and the total wake-to-resume delay to the cycle. A design that dropped a synchronizer stage or miscounted the latency timer would be one cycle off there. Selecting long flash latency shows whether the resume latency is chosen from the code location. Two further cases check the captured settings: one alters them during standby, and one starts a wake pulse during the entry delay. A design that read live settings, or that lost a wake arriving in the entry window, would resume at the wrong cycle or not at all.

// File: rtl/stbw_pkg.sv
package stbw_pkg;

  typedef enum logic [2:0] {
    ST_RUN         = 3'd0,
    ST_ENTER       = 3'd1,
    ST_STANDBY     = 3'd2,
    ST_QUALIFY     = 3'd3,
    ST_RESUME_WAIT = 3'd4
  } stbw_state_e;

  typedef enum logic [1:0] {
    MEM_FLASH_ACT = 2'd0,
    MEM_FLASH_SLP = 2'd1,
    MEM_SRAM      = 2'd2,
    MEM_SRAM_ALT  = 2'd3
  } stbw_mem_e;

endpackage

// File: rtl/stbw_sync.sv
module stbw_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= RST_VAL;
        else        chain <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/stbw_qual.sv
module stbw_qual #(
  parameter int QW = 6,
  localparam int RW = QW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic          wake_s,
  input  logic [RW-1:0] need,
  output logic          hit
);

  localparam logic [RW-1:0] RUN_MAX = {RW{1'b1}};

  logic [RW-1:0] low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run <= '0;
    end else if (!active || wake_s) begin
      low_run <= '0;
    end else if (low_run != RUN_MAX) begin
      low_run <= low_run + 1'b1;
    end
  end

  assign hit = active && !wake_s && (low_run == need - 1'b1);

  // R3: an accepted wake always follows at least one earlier low sample
  assert_hit_after_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> $past(!wake_s));

  // R3: the required run is never below two samples
  assert_need_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (need >= RW'(2)));

endmodule

// File: rtl/stbw_seq.sv
module stbw_seq
  import stbw_pkg::*;
#(
  parameter int ENTRY_DLY  = 32,
  parameter int FAST_LAT   = 12,
  parameter int SLOW_LAT   = 1125,
  parameter int UNQUAL_MIN = 12,
  parameter int QUAL_BASE  = 2,
  parameter int QW         = 6,
  localparam int RW   = QW + 1,
  localparam int MAXD = (SLOW_LAT > ENTRY_DLY) ?
                        ((SLOW_LAT > FAST_LAT) ? SLOW_LAT : FAST_LAT) :
                        ((ENTRY_DLY > FAST_LAT) ? ENTRY_DLY : FAST_LAT),
  localparam int CW   = $clog2(MAXD + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          idle_req,
  input  logic          wake_s,
  input  logic          hit,
  input  logic          qual_en,
  input  logic [QW-1:0] qual_width,
  input  logic [1:0]    code_mem,
  output logic          qual_active,
  output logic [RW-1:0] need,
  output logic          clkout_hi,
  output logic          core_clk_en,
  output logic          resume_pulse
);

  stbw_state_e   st;
  logic [CW-1:0] cnt;
  logic          pend;
  logic          qen_q;
  logic [QW-1:0] qw_q;
  stbw_mem_e     mem_q;
  logic [CW-1:0] lat_m1;

  assign lat_m1      = (mem_q == MEM_FLASH_SLP) ? CW'(SLOW_LAT - 1) : CW'(FAST_LAT - 1);
  assign need        = qen_q ? (RW'(QUAL_BASE) + RW'(qw_q)) : RW'(UNQUAL_MIN);
  assign qual_active = (st != ST_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= ST_RUN;
      cnt          <= '0;
      pend         <= 1'b0;
      qen_q        <= 1'b0;
      qw_q         <= '0;
      mem_q        <= MEM_FLASH_ACT;
      clkout_hi    <= 1'b0;
      core_clk_en  <= 1'b1;
      resume_pulse <= 1'b0;
    end else begin
      resume_pulse <= 1'b0;
      unique case (st)
        ST_RUN: begin
          pend <= 1'b0;
          if (idle_req) begin
            qen_q <= qual_en;
            qw_q  <= qual_width;
            mem_q <= stbw_mem_e'(code_mem);
            cnt   <= '0;
            st    <= ST_ENTER;
          end
        end
        ST_ENTER: begin
          if (hit) pend <= 1'b1;
          if (cnt == CW'(ENTRY_DLY - 1)) begin
            st          <= ST_STANDBY;
            clkout_hi   <= 1'b1;
            core_clk_en <= 1'b0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_STANDBY: begin
          if (pend || hit) begin
            pend <= 1'b0;
            cnt  <= '0;
            st   <= ST_RESUME_WAIT;
          end else if (!wake_s) begin
            st <= ST_QUALIFY;
          end
        end
        ST_QUALIFY: begin
          if (hit) begin
            cnt <= '0;
            st  <= ST_RESUME_WAIT;
          end else if (wake_s) begin
            st <= ST_STANDBY;
          end
        end
        ST_RESUME_WAIT: begin
          if (cnt == lat_m1) begin
            st           <= ST_RUN;
            resume_pulse <= 1'b1;
            clkout_hi    <= 1'b0;
            core_clk_en  <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= ST_RUN;
      endcase
    end
  end

  // R7: the resume strobe lasts one cycle
  assert_resume_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    resume_pulse |=> !resume_pulse);

  // R7: the strobe coincides with the clock being released
  assert_resume_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    resume_pulse |-> (core_clk_en && !clkout_hi));

  // R1: the standby indication and a running core clock never coexist
  assert_gate_match_R1: assert property (@(posedge clk) disable iff (!rst_n)
    clkout_hi |-> !core_clk_en);

  // R8: captured settings hold while away from the running state
  assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_RUN && $past(st) != ST_RUN) |->
      ($stable(mem_q) && $stable(qw_q) && $stable(qen_q)));

  // R5, R6: the latency counter never runs past the selected latency
  assert_wait_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RESUME_WAIT) |-> (cnt <= lat_m1));

endmodule

// File: rtl/stbw_ctrl.sv
module stbw_ctrl #(
  parameter int ENTRY_DLY  = 32,
  parameter int FAST_LAT   = 12,
  parameter int SLOW_LAT   = 1125,
  parameter int UNQUAL_MIN = 12,
  parameter int QUAL_BASE  = 2,
  parameter int QW         = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          idle_req,
  input  logic          wake_n,
  input  logic          qual_en,
  input  logic [QW-1:0] qual_width,
  input  logic [1:0]    code_mem,
  output logic          clkout_hi,
  output logic          core_clk_en,
  output logic          resume_pulse
);

  localparam int RW = QW + 1;

  logic          wake_s;
  logic          hit;
  logic          qual_active;
  logic [RW-1:0] need;

  stbw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (wake_n),
    .dout (wake_s)
  );

  stbw_qual #(.QW(QW)) u_qual (
    .clk   (clk),
    .rst_n (rst_n),
    .active(qual_active),
    .wake_s(wake_s),
    .need  (need),
    .hit   (hit)
  );

  stbw_seq #(
    .ENTRY_DLY (ENTRY_DLY),
    .FAST_LAT  (FAST_LAT),
    .SLOW_LAT  (SLOW_LAT),
    .UNQUAL_MIN(UNQUAL_MIN),
    .QUAL_BASE (QUAL_BASE),
    .QW        (QW)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .idle_req    (idle_req),
    .wake_s      (wake_s),
    .hit         (hit),
    .qual_en     (qual_en),
    .qual_width  (qual_width),
    .code_mem    (code_mem),
    .qual_active (qual_active),
    .need        (need),
    .clkout_hi   (clkout_hi),
    .core_clk_en (core_clk_en),
    .resume_pulse(resume_pulse)
  );

  // R2: an accepted wake only ever happens while away from the running state
  assert_hit_only_standby_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> qual_active);

endmodule

// File: tb/test_stbw_ctrl.sv
module test_stbw_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       idle_req = 1'b0;
  logic       wake_n = 1'b1;
  logic       qual_en = 1'b0;
  logic [5:0] qual_width = 6'd0;
  logic [1:0] code_mem = 2'd0;
  logic       clkout_hi;
  logic       core_clk_en;
  logic       resume_pulse;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  stbw_ctrl i_stbw_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .idle_req    (idle_req),
    .wake_n      (wake_n),
    .qual_en     (qual_en),
    .qual_width  (qual_width),
    .code_mem    (code_mem),
    .clkout_hi   (clkout_hi),
    .core_clk_en (core_clk_en),
    .resume_pulse(resume_pulse)
  );

  // fields: qual_en[16] qual_width[15:10] code_mem[9:8] pulse_len[7:0]
  localparam int NV = 12;
  localparam logic [16:0] VEC [0:NV-1] = '{
    {1'b0, 6'd0,  2'd0, 8'd12},
    {1'b0, 6'd0,  2'd2, 8'd20},
    {1'b0, 6'd0,  2'd1, 8'd12},
    {1'b1, 6'd0,  2'd0, 8'd2},
    {1'b1, 6'd63, 2'd2, 8'd65},
    {1'b1, 6'd63, 2'd0, 8'd64},
    {1'b0, 6'd0,  2'd0, 8'd11},
    {1'b1, 6'd10, 2'd1, 8'd12},
    {1'b1, 6'd10, 2'd0, 8'd11},
    {1'b0, 6'd0,  2'd3, 8'd12},
    {1'b1, 6'd0,  2'd2, 8'd1},
    {1'b1, 6'd5,  2'd3, 8'd30}
  };

  function automatic int run_len(bit qe, int q);
    return qe ? (2 + q) : 12;
  endfunction

  function automatic int lat_of(int mem);
    return (mem == 1) ? 1125 : 12;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Starts at a negedge; returns at the 40th negedge after acceptance.
  task automatic enter_standby(bit qe, int q, int mem);
    int first;
    qual_en = qe;
    qual_width = 6'(q);
    code_mem = 2'(mem);
    idle_req = 1'b1;
    @(negedge clk);
    idle_req = 1'b0;
    first = (clkout_hi) ? 1 : 0;
    for (int k = 2; k <= 40; k++) begin
      @(negedge clk);
      if (clkout_hi && first == 0) first = k;
    end
    chk(first == 33, "R1 entry delay", first, 33);
    chk(core_clk_en == 1'b0, "R1 clock gated", core_clk_en, 0);
  endtask

  // exp == 0 means the pulse must be ignored.
  task automatic wake_pulse(int n, int exp, string req);
    int first = 0;
    int highs = 0;
    int limit = (exp == 0) ? (n + 40) : (exp + 4);
    wake_n = 1'b0;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk);
      if (i == n) wake_n = 1'b1;
      if (resume_pulse) begin
        highs++;
        if (first == 0) first = i;
      end
    end
    wake_n = 1'b1;
    if (exp == 0) begin
      chk(highs == 0, {req, " short pulse ignored"}, highs, 0);
      chk(clkout_hi == 1'b1, {req, " still in standby"}, clkout_hi, 1);
    end else begin
      chk(first == exp, {req, " wake to resume"}, first, exp);
      chk(highs == 1, "R7 single strobe", highs, 1);
      chk(core_clk_en && !clkout_hi, "R7 clock released", {core_clk_en, clkout_hi}, 2);
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(clkout_hi == 1'b0, "R10 clkout_hi reset", clkout_hi, 0);
    chk(core_clk_en == 1'b1, "R10 core_clk_en reset", core_clk_en, 1);
    chk(resume_pulse == 1'b0, "R10 resume reset", resume_pulse, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      bit qe = VEC[v][16];
      int q = int'(VEC[v][15:10]);
      int mem = int'(VEC[v][9:8]);
      int n = int'(VEC[v][7:0]);
      int w = run_len(qe, q);
      int l = lat_of(mem);
      string req = qe ? "R3" : "R2";
      if (mem == 1) req = {req, "/R6/R4"};
      else req = {req, "/R5/R4"};
      enter_standby(qe, q, mem);
      if (n >= w) begin
        wake_pulse(n, w + l + 2, req);
      end else begin
        wake_pulse(n, 0, req);
        wake_pulse(80, w + l + 2, req);
      end
      repeat (2) @(negedge clk);
    end

    // R8: settings changed after entry are ignored; R1: idle_req in standby ignored
    enter_standby(1'b0, 0, 0);
    code_mem = 2'd1;
    qual_en = 1'b1;
    qual_width = 6'd0;
    idle_req = 1'b1;
    @(negedge clk);
    idle_req = 1'b0;
    chk(clkout_hi == 1'b1, "R1 idle_req in standby ignored", clkout_hi, 1);
    wake_pulse(12, 26, "R8 captured settings");
    repeat (2) @(negedge clk);

    // R9: wake that completes during the entry delay is held pending
    begin
      int first_ck = 0;
      int first_rs = 0;
      qual_en = 1'b0;
      qual_width = 6'd0;
      code_mem = 2'd0;
      idle_req = 1'b1;
      @(negedge clk);
      idle_req = 1'b0;
      wake_n = 1'b0;
      for (int k = 2; k <= 60; k++) begin
        @(negedge clk);
        if (k == 13) wake_n = 1'b1;
        if (clkout_hi && first_ck == 0) first_ck = k;
        if (resume_pulse && first_rs == 0) first_rs = k;
      end
      chk(first_ck == 33, "R9 entry still completes", first_ck, 33);
      chk(first_rs == 46, "R9 pending wake honoured", first_rs, 46);
    end

    // R1: idle_req while running is accepted again after a resume
    repeat (2) @(negedge clk);
    enter_standby(1'b1, 1, 2);
    wake_pulse(3, 3 + 12 + 2, "R3/R5 exact run of three");

    // R10: reset in the middle of standby
    enter_standby(1'b0, 0, 1);
    rst_n = 1'b0;
    @(negedge clk);
    chk(clkout_hi == 1'b0 && core_clk_en == 1'b1, "R10 reset during standby",
        {clkout_hi, core_clk_en}, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule